// File: doc/BRIEF.md
# Program Counter and Control-Flow Unit

This block owns the instruction address of a small 8-bit core. It keeps two 16-bit program counters: a normal one and one used only while the core is in interrupt mode. It also keeps a single link register and a 16-bit pause timer. Each cycle in which a decoded instruction is offered, the block moves the active counter. The control-flow opcodes load it from an immediate word, a word read through the zero page, the link register, a table entry, or a signed byte offset. Every other opcode advances it by the instruction length that the decoder reports.

The surrounding core presents the opcode, its length in bytes, and one 16-bit operand word. That word is the two-byte immediate, the word fetched from the zero page, or the table entry read at `tbl_addr`. The core also presents the zero-page byte and an interrupt request. The block returns the fetch address and an issue-ready flag. While the pause timer is non-zero, issue-ready is low and the block ignores offered instructions and interrupt requests. An interrupt is taken only at an instruction boundary. Interrupt mode ends when a return executes in that mode.

Top module: `flow_ctl`

## Requirements
- R1: After reset, `fetch_pc` equals RESET_PC (default 0x0000), `in_irq` is 0, `issue_rdy` is 1 and the link register holds 0x0000, so `tbl_addr` equals `zp_val`.
- R2: A non-control opcode that is executed advances the active counter by `op_len`. Opcode 0xEE is a no-operation that advances it by 1 and ignores `op_len`.
- R3: Opcode 0xEC loads the active counter from `operand`. Opcode 0xED does the same and also stores the active counter plus 3 into the link register.
- R4: Opcode 0xEF, executed outside interrupt mode, loads the normal counter from the link register.
- R5: Opcode 0xFC loads the active counter from `operand`, which is the word read through the zero page. Opcode 0xFD does the same and also stores the active counter plus 2 into the link register.
- R6: Opcode 0xFE adds `operand[7:0]`, sign-extended, to the active counter plus 2. The sum wraps modulo 2^16.
- R7: `tbl_addr` always equals the link register plus `zp_val`, with `zp_val` zero-extended. Opcode 0xFF loads the active counter from `operand`, which is the word read at that address.
- R8: When `issue_rdy` is 1, `irq` is 1 and `in_irq` is 0, the block enters interrupt mode. The interrupt counter is loaded with IRQ_VEC (default 0xFF00). The normal counter keeps its value, and any instruction offered in that cycle is not executed. While `in_irq` is 1, `irq` has no effect.
- R9: In interrupt mode every executed instruction updates only the interrupt counter. Opcode 0xEF clears `in_irq`, and fetch then resumes from the normal counter, which still holds its value from before the interrupt. The link register is not changed by this return.
- R10: A `tmr_load` pulse with value N makes `issue_rdy` low for exactly the next N cycles. During those cycles `fetch_pc` does not change, and offered instructions and `irq` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | A decoded instruction is offered this cycle |
| opcode | input | 8 | Opcode byte |
| op_len | input | 2 | Byte length of a non-control instruction |
| operand | input | 16 | Immediate word, zero-page word or table entry |
| zp_val | input | 8 | Zero-page byte used as the table index |
| irq | input | 1 | Interrupt request |
| tmr_load | input | 1 | Load the pause timer |
| tmr_value | input | 16 | Cycles to pause |
| fetch_pc | output | 16 | Address of the next instruction to fetch |
| issue_rdy | output | 1 | Timer idle; an instruction may issue |
| in_irq | output | 1 | Interrupt mode active |
| tbl_addr | output | 16 | Link register plus zero-page byte |

## Verification
The bench exercises plain opcodes with different lengths, each absolute, indirect and table target, and branch offsets that are positive, negative, +127, -128 and one that wraps past 0xFFFF. Together these separate a correct sign extension and base address from a wrong one. A call followed by a table lookup and then a return shows whether the link value is the address after the call. The same jump and nop are repeated inside interrupt mode, which shows whether the right counter moves. One interrupt arrives together with a jump and another arrives during a pause. These show whether the boundary rule and the stall hold back both issue and acceptance.

// File: rtl/flow_ctl.sv
module flow_ctl #(
  parameter int PCW = 16,
  parameter int TW = 16,
  parameter logic [PCW-1:0] RESET_PC = '0,
  parameter logic [PCW-1:0] IRQ_VEC = 16'hFF00
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           op_valid,
  input  logic [7:0]     opcode,
  input  logic [1:0]     op_len,
  input  logic [PCW-1:0] operand,
  input  logic [7:0]     zp_val,
  input  logic           irq,
  input  logic           tmr_load,
  input  logic [TW-1:0]  tmr_value,
  output logic [PCW-1:0] fetch_pc,
  output logic           issue_rdy,
  output logic           in_irq,
  output logic [PCW-1:0] tbl_addr
);
  localparam logic [7:0] OP_JMP = 8'hEC, OP_CALL = 8'hED, OP_NOP = 8'hEE, OP_RET = 8'hEF;
  localparam logic [7:0] OP_JMPI = 8'hFC, OP_CALLI = 8'hFD, OP_BR = 8'hFE, OP_TBL = 8'hFF;

  logic [PCW-1:0] norm_pc, int_pc, link;
  logic [TW-1:0]  tmr;
  logic [PCW-1:0] nxt, link_nxt;
  logic           wr_link;

  assign issue_rdy = (tmr == '0);
  assign fetch_pc  = in_irq ? int_pc : norm_pc;
  assign tbl_addr  = link + {{(PCW-8){1'b0}}, zp_val};

  wire take_irq = issue_rdy & irq & ~in_irq;
  wire exec     = issue_rdy & op_valid & ~take_irq;
  wire irq_ret  = exec & in_irq & (opcode == OP_RET);

  always_comb begin
    nxt      = fetch_pc + PCW'(op_len);
    link_nxt = fetch_pc + PCW'(3);
    wr_link  = 1'b0;
    case (opcode)
      OP_JMP:   nxt = operand;
      OP_CALL:  begin nxt = operand; wr_link = 1'b1; end
      OP_NOP:   nxt = fetch_pc + PCW'(1);
      OP_RET:   nxt = link;
      OP_JMPI:  nxt = operand;
      OP_CALLI: begin nxt = operand; wr_link = 1'b1; link_nxt = fetch_pc + PCW'(2); end
      OP_BR:    nxt = fetch_pc + PCW'(2) + {{(PCW-8){operand[7]}}, operand[7:0]};
      OP_TBL:   nxt = operand;
      default:  ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      norm_pc <= RESET_PC;
      int_pc  <= IRQ_VEC;
      link    <= '0;
      in_irq  <= 1'b0;
    end else if (take_irq) begin
      in_irq <= 1'b1;
      int_pc <= IRQ_VEC;
    end else if (irq_ret) begin
      in_irq <= 1'b0;
    end else if (exec) begin
      if (in_irq) int_pc <= nxt;
      else        norm_pc <= nxt;
      if (wr_link) link <= link_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           tmr <= '0;
    else if (tmr_load)    tmr <= tmr_value;
    else if (!issue_rdy)  tmr <= tmr - TW'(1);
  end
endmodule

module flow_ctl_chk #(
  parameter int PCW = 16,
  parameter int TW = 16,
  parameter logic [PCW-1:0] IRQ_VEC = 16'hFF00
) (
  input logic           clk,
  input logic           rst_n,
  input logic           op_valid,
  input logic [7:0]     opcode,
  input logic [PCW-1:0] operand,
  input logic           irq,
  input logic           tmr_load,
  input logic [TW-1:0]  tmr,
  input logic [PCW-1:0] fetch_pc,
  input logic           issue_rdy,
  input logic           in_irq
);
  wire go = issue_rdy & op_valid & ~(irq & ~in_irq);

  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_rdy |=> $stable(fetch_pc));

  p_tmr_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!issue_rdy && !tmr_load) |=> tmr == $past(tmr) - TW'(1));

  p_irq_enter_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_rdy && irq && !in_irq) |=> (in_irq && fetch_pc == IRQ_VEC));

  p_irq_leave_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (go && in_irq && opcode == 8'hEF) |=> !in_irq);

  p_jump_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (go && opcode == 8'hEC) |=> fetch_pc == $past(operand));

  p_branch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (go && opcode == 8'hFE) |=>
      fetch_pc == $past(fetch_pc) + PCW'(2) + {{(PCW-8){$past(operand[7])}}, $past(operand[7:0])});
endmodule

bind flow_ctl flow_ctl_chk #(.PCW(PCW), .TW(TW), .IRQ_VEC(IRQ_VEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode), .operand(operand),
  .irq(irq), .tmr_load(tmr_load), .tmr(tmr), .fetch_pc(fetch_pc),
  .issue_rdy(issue_rdy), .in_irq(in_irq));

// File: tb/flow_ctl_bench.sv
`timescale 1ns/1ps
module flow_ctl_bench;
  logic clk = 0, rst_n = 0;
  logic op_valid = 0, irq = 0, tmr_load = 0;
  logic [7:0] opcode = 0, zp_val = 0;
  logic [1:0] op_len = 0;
  logic [15:0] operand = 0, tmr_value = 0;
  logic [15:0] fetch_pc, tbl_addr;
  logic issue_rdy, in_irq;

  always #5 clk = ~clk;

  flow_ctl u_flow_ctl (.*);

  int vectors = 0, fails = 0;
  bit done = 0;
  int mp = 0, mi = 16'hFF00, ml = 0, mt = 0;
  bit mirq = 0;

  task automatic chk(string tag, string what, int act, int exp);
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic apply(bit v, logic [7:0] op, logic [1:0] len, logic [15:0] opnd,
                       logic [7:0] zp, bit rq, bit tld, logic [15:0] tv, string tag);
    int cur, nx;
    bit rdy;
    op_valid = v; opcode = op; op_len = len; operand = opnd; zp_val = zp;
    irq = rq; tmr_load = tld; tmr_value = tv;
    #1;
    vectors++;
    rdy = (mt == 0);
    chk(tag, "fetch_pc", int'(fetch_pc), mirq ? mi : mp);
    chk(tag, "issue_rdy", int'(issue_rdy), int'(rdy));
    chk(tag, "in_irq", int'(in_irq), int'(mirq));
    chk(tag, "tbl_addr", int'(tbl_addr), (ml + zp) % 65536);
    @(posedge clk);
    if (rdy && rq && !mirq) begin
      mirq = 1; mi = 16'hFF00;
    end else if (rdy && v) begin
      cur = mirq ? mi : mp;
      nx = cur + len;
      if (op == 8'hEF && mirq) mirq = 0;
      else begin
        if (op == 8'hEC || op == 8'hFC || op == 8'hFF) nx = opnd;
        else if (op == 8'hED) begin nx = opnd; ml = (cur + 3) % 65536; end
        else if (op == 8'hFD) begin nx = opnd; ml = (cur + 2) % 65536; end
        else if (op == 8'hEE) nx = cur + 1;
        else if (op == 8'hEF) nx = ml;
        else if (op == 8'hFE) nx = cur + 2 + (opnd[7] ? int'(opnd[7:0]) - 256 : int'(opnd[7:0]));
        nx = (nx + 65536) % 65536;
        if (mirq) mi = nx; else mp = nx;
      end
    end
    if (tld) mt = tv; else if (mt != 0) mt--;
    @(negedge clk);
  endtask

  task automatic idle(string tag);
    apply(0, 8'h00, 2'd0, 16'h0, 8'h00, 0, 0, 16'h0, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    idle("R1 reset state");
    apply(0, 8'h00, 0, 0, 8'h42, 0, 0, 0, "R1 tbl_addr from zero link");
    apply(1, 8'h10, 2'd1, 16'h0, 0, 0, 0, 0, "R2 len1");
    apply(1, 8'h20, 2'd2, 16'h0, 0, 0, 0, 0, "R2 len2");
    apply(1, 8'h41, 2'd3, 16'h0, 0, 0, 0, 0, "R2 len3");
    apply(1, 8'hEE, 2'd3, 16'h0, 0, 0, 0, 0, "R2 nop ignores len");
    apply(1, 8'hEC, 2'd1, 16'h1234, 0, 0, 0, 0, "R3 jump");
    apply(1, 8'hED, 2'd1, 16'h2000, 0, 0, 0, 0, "R3 call");
    apply(0, 8'h00, 0, 0, 8'h05, 0, 0, 0, "R7 tbl_addr link+zp");
    apply(1, 8'hFF, 0, 16'h3000, 8'h05, 0, 0, 0, "R7 table dispatch");
    apply(1, 8'hEF, 0, 16'h0, 0, 0, 0, 0, "R4 return");
    idle("R4 after return");
    apply(1, 8'hFC, 0, 16'h4000, 0, 0, 0, 0, "R5 indirect jump");
    apply(1, 8'hFD, 0, 16'h5000, 0, 0, 0, 0, "R5 indirect call");
    apply(0, 8'h00, 0, 0, 8'hFF, 0, 0, 0, "R5 link value");
    apply(1, 8'hFE, 0, 16'h0010, 0, 0, 0, 0, "R6 branch +16");
    apply(1, 8'hFE, 0, 16'h00F0, 0, 0, 0, 0, "R6 branch -16");
    apply(1, 8'hFE, 0, 16'hAA7F, 0, 0, 0, 0, "R6 branch +127");
    apply(1, 8'hFE, 0, 16'h0080, 0, 0, 0, 0, "R6 branch -128");
    apply(1, 8'hEC, 0, 16'hFFFF, 0, 0, 0, 0, "R6 setup wrap");
    apply(1, 8'hFE, 0, 16'h0001, 0, 0, 0, 0, "R6 branch wrap");
    idle("R6 after wrap");
    apply(0, 8'h00, 0, 0, 0, 0, 1, 16'd3, "R10 load timer");
    apply(1, 8'hEC, 0, 16'h7777, 0, 0, 0, 0, "R10 jump ignored");
    apply(0, 8'h00, 0, 0, 0, 1, 0, 0, "R10 irq ignored");
    apply(1, 8'h10, 2'd1, 16'h0, 0, 0, 0, 0, "R10 op ignored");
    idle("R10 timer expired");
    apply(1, 8'hEC, 0, 16'h0500, 0, 1, 0, 0, "R8 irq beats jump");
    apply(1, 8'hEE, 0, 16'h0, 0, 1, 0, 0, "R8 irq ignored in irq, R9 nop");
    apply(1, 8'hEC, 0, 16'h0100, 0, 0, 0, 0, "R9 jump in irq");
    apply(1, 8'hED, 0, 16'h0200, 0, 0, 0, 0, "R9 call in irq");
    apply(1, 8'hEF, 0, 16'h0, 0, 0, 0, 0, "R9 return leaves irq");
    apply(0, 8'h00, 0, 0, 8'h01, 0, 0, 0, "R9 normal pc restored");
    apply(1, 8'hEF, 0, 16'h0, 0, 0, 0, 0, "R4 return via irq link");
    apply(0, 8'h00, 0, 0, 0, 0, 1, 16'd1, "R10 one-cycle pause");
    apply(0, 8'h00, 0, 0, 0, 1, 0, 0, "R10 irq held off");
    apply(0, 8'h00, 0, 0, 0, 1, 0, 0, "R8 irq after pause");
    idle("R8 second entry vector");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule